// File: doc/BRIEF.md
# Floating-Point Compare Mask Unit

This block compares floating-point vector elements with a second vector or with one scalar. For each element it produces one bit of a packed result mask. It handles half, single and double precision. Each comparison follows IEEE rules for unordered operands and signed zeros. The unit also keeps a sticky invalid-operation flag and reports operation codes it cannot execute.

A caller raises `start_i` for one cycle while the unit is idle. In that cycle the unit samples the opcode, the operand form, the element width, the rounding-mode field, the element count, the scalar, the mask register v0 and the old destination mask. It then evaluates one element per clock, from index 0 upward. When the last element is done it pulses `done_o`, and the result stays on `mask_o` until the next accepted start.

The vector operand buses must stay stable while `busy_o` is high. Each element lives in its own 64-bit lane. A narrower element uses only the low bits of its lane.

Top module: `fp_cmp_mask_unit`

## Requirements
- R1: The opcode is read from `funct6_i`: 011000 equal, 011001 less-or-equal, 011011 less-than, 011100 not-equal, 011101 greater-than, 011111 greater-or-equal. When `form_i` is 001 (vector-vector), only equal, less-or-equal, less-than and not-equal are legal. When `form_i` is 101 (vector-scalar), all six are legal. Any other form or opcode is illegal.
- R2: Either of these also makes the operation illegal: `sew_i` = 0 (8-bit), or `frm_i` greater than 4. For an illegal operation, `done_o` pulses one cycle after the start, with `illegal_o` = 1, `mask_o` equal to the old mask and `flag_nv_o` = 0.
- R3: When either operand is NaN, equal, less-than, less-or-equal, greater-than and greater-or-equal yield 0, and not-equal yields 1.
- R4: Positive and negative zero compare equal, and neither is less than the other.
- R5: Non-NaN values are ordered by value. Negative numbers, infinities and subnormals are included.
- R6: `flag_nv_o` is cleared at each accepted start and then set sticky. An active element sets it under either of two conditions: an ordering compare (less, less-or-equal, greater, greater-or-equal) with any NaN operand, or equal or not-equal with a signaling NaN operand.
- R7: An element is active when `vm_i` = 1, or when bit i of `v0_i` is 1. Inactive elements, and elements at index `vl_i` or above, keep the bit from `old_mask_i`.
- R8: In the vector-scalar form, a scalar narrower than 64 bits is valid only if all bits above the element width are 1. Any other scalar is treated as the canonical quiet NaN.
- R9: `sew_i` codes are 1 = 16-bit, 2 = 32-bit and 3 = 64-bit. Element i is taken from bits [64i +: 64] of each vector bus, using the low element-width bits only.
- R10: With `vl_i` = n > 0, `done_o` is high for exactly one cycle, n+1 cycles after the start is driven (the start edge plus one edge per element). With n = 0, it pulses after one cycle. Between operations, `mask_o` holds its value.
- R11: A `start_i` seen while `busy_o` is high is ignored.
- R12: After reset, `busy_o`, `done_o`, `illegal_o`, `flag_nv_o` and `mask_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| funct6_i | input | 6 | Compare opcode |
| vm_i | input | 1 | 1 = all elements active, 0 = gated by v0 |
| form_i | input | 3 | Operand form: 001 vector-vector, 101 vector-scalar |
| sew_i | input | 2 | Element width code |
| vl_i | input | $clog2(NUM_ELEM+1) | Element count |
| frm_i | input | 3 | Rounding-mode field (legality only) |
| vs2_i | input | 64*NUM_ELEM | First operand vector, one lane per element |
| vs1_i | input | 64*NUM_ELEM | Second operand vector |
| scal_i | input | 64 | Scalar operand, NaN-boxed when narrow |
| v0_i | input | NUM_ELEM | Element enable mask |
| old_mask_i | input | NUM_ELEM | Previous destination mask |
| busy_o | output | 1 | Elements are being evaluated |
| done_o | output | 1 | One-cycle completion pulse |
| mask_o | output | NUM_ELEM | Result mask |
| flag_nv_o | output | 1 | Invalid-operation flag for the last operation |
| illegal_o | output | 1 | Last operation was illegal |

## Verification
A wrong element index, or a counter that runs off by one, shows up as a result bit in the wrong lane, or as an old-mask bit that was overwritten. It also shifts the `done_o` pulse by a cycle, and the scoreboard sees all of this at that pulse. A decoder fault shows up within one cycle of the start, as a wrong `illegal_o` or a mask that is not the old one. Swapped sign handling flips bits only for negative operands or for mixed-sign pairs. For this reason the stimulus pairs negative values, signed zeros and both NaN kinds in every width.

// File: rtl/fpcmp_pkg.sv
// Shared types and codes for the floating-point compare mask unit.
package fpcmp_pkg;
    localparam int LANE_W = 64;

    typedef enum logic [5:0] {
        CMP_EQ = 6'b011000,
        CMP_LE = 6'b011001,
        CMP_LT = 6'b011011,
        CMP_NE = 6'b011100,
        CMP_GT = 6'b011101,
        CMP_GE = 6'b011111
    } cmp_op_e;

    typedef enum logic [1:0] {
        SEW_8  = 2'd0,
        SEW_16 = 2'd1,
        SEW_32 = 2'd2,
        SEW_64 = 2'd3
    } sew_e;

    localparam logic [2:0] FORM_VV = 3'b001;
    localparam logic [2:0] FORM_VS = 3'b101;

    // Decoded operand: sign, magnitude bits (exponent and mantissa), class bits.
    typedef struct packed {
        logic              sign;
        logic [LANE_W-2:0] mag;
        logic              nan;
        logic              snan;
        logic              zero;
    } fp_class_t;
endpackage

// File: rtl/fpcmp_decode.sv
// Legality decode for one compare request.
// Assumes: the request fields are valid in the cycle they are decoded.
module fpcmp_decode
    import fpcmp_pkg::*;
(
    input  logic [5:0] funct6_i,
    input  logic [2:0] form_i,
    input  logic [1:0] sew_i,
    input  logic [2:0] frm_i,
    output logic       illegal_o,
    output logic       scalar_o
);
    logic base_ok;
    logic ext_ok;
    logic form_ok;

    // Sort the opcode into the set both forms accept and the scalar-only set.
    always_comb begin
        base_ok = 1'b0;
        ext_ok  = 1'b0;
        case (funct6_i)
            CMP_EQ, CMP_LE, CMP_LT, CMP_NE: base_ok = 1'b1;
            CMP_GT, CMP_GE:                 ext_ok  = 1'b1;
            default: ;
        endcase
    end

    // Combine the opcode set with the form, the width and the rounding-mode field.
    always_comb begin
        form_ok   = ((form_i == FORM_VV) && base_ok) ||
                    ((form_i == FORM_VS) && (base_ok || ext_ok));
        illegal_o = !form_ok || (sew_i == SEW_8) || (frm_i > 3'd4);
        scalar_o  = (form_i == FORM_VS);
    end
endmodule

// File: rtl/fpcmp_classify.sv
// Splits one raw lane into sign, magnitude and NaN/zero class for the selected width.
// Assumes: narrow values sit in the low bits of the lane; box_en_i requests the
// upper-ones check, and a failed check yields the canonical quiet NaN.
module fpcmp_classify
    import fpcmp_pkg::*;
(
    input  logic [LANE_W-1:0] raw_i,
    input  sew_e              sew_i,
    input  logic              box_en_i,
    output fp_class_t         cls_o
);
    logic              sign;
    logic [LANE_W-2:0] mag;
    logic              exp_ones;
    logic              man_nz;
    logic              quiet;
    logic              boxed;

    // Pick the field positions for the element width.
    always_comb begin
        case (sew_i)
            SEW_16: begin
                sign     = raw_i[15];
                mag      = {48'd0, raw_i[14:0]};
                exp_ones = &raw_i[14:10];
                man_nz   = |raw_i[9:0];
                quiet    = raw_i[9];
                boxed    = &raw_i[63:16];
            end
            SEW_32: begin
                sign     = raw_i[31];
                mag      = {32'd0, raw_i[30:0]};
                exp_ones = &raw_i[30:23];
                man_nz   = |raw_i[22:0];
                quiet    = raw_i[22];
                boxed    = &raw_i[63:32];
            end
            default: begin
                sign     = raw_i[63];
                mag      = raw_i[62:0];
                exp_ones = &raw_i[62:52];
                man_nz   = |raw_i[51:0];
                quiet    = raw_i[51];
                boxed    = 1'b1;
            end
        endcase
    end

    // Form the class record, replacing a badly boxed scalar by the canonical NaN.
    always_comb begin
        cls_o = '0;
        if (box_en_i && !boxed) begin
            cls_o.nan = 1'b1;
        end else begin
            cls_o.sign = sign;
            cls_o.mag  = mag;
            cls_o.nan  = exp_ones && man_nz;
            cls_o.snan = exp_ones && man_nz && !quiet;
            cls_o.zero = (mag == '0);
        end
    end
endmodule

// File: rtl/fpcmp_elem.sv
// Compares one classified pair and reports the result bit and the invalid condition.
// Assumes: both operands are classified for the same width.
module fpcmp_elem
    import fpcmp_pkg::*;
(
    input  fp_class_t a_i,
    input  fp_class_t b_i,
    input  cmp_op_e   op_i,
    output logic      res_o,
    output logic      nv_o
);
    logic any_nan;
    logic any_snan;
    logic both_zero;
    logic eq;
    logic lt_ab;
    logic lt_ba;
    logic ordering;

    // Strict sign-magnitude less-than for ordered, not-both-zero operands.
    function automatic logic less(input fp_class_t x, input fp_class_t y);
        if (x.sign != y.sign) return x.sign;
        if (x.sign)           return x.mag > y.mag;
        return x.mag < y.mag;
    endfunction

    // Relations between the two operands.
    always_comb begin
        any_nan   = a_i.nan | b_i.nan;
        any_snan  = a_i.snan | b_i.snan;
        both_zero = a_i.zero & b_i.zero;
        eq    = !any_nan && (both_zero || (a_i.sign == b_i.sign && a_i.mag == b_i.mag));
        lt_ab = !any_nan && !both_zero && less(a_i, b_i);
        lt_ba = !any_nan && !both_zero && less(b_i, a_i);
    end

    // Select the relation the opcode asks for, and the invalid condition for it.
    always_comb begin
        case (op_i)
            CMP_EQ:  res_o = eq;
            CMP_NE:  res_o = !eq;
            CMP_LT:  res_o = lt_ab;
            CMP_LE:  res_o = lt_ab | eq;
            CMP_GT:  res_o = lt_ba;
            CMP_GE:  res_o = lt_ba | eq;
            default: res_o = 1'b0;
        endcase
        ordering = (op_i != CMP_EQ) && (op_i != CMP_NE);
        nv_o     = ordering ? any_nan : any_snan;
    end

    // Equal, less and greater come from separate logic and must never overlap.
    always_comb begin
        AST_ORDER_EXCLUSIVE: assert ($onehot0({eq, lt_ab, lt_ba})); // R5
    end
endmodule

// File: rtl/fp_cmp_mask_unit.sv
// Floating-point compare mask unit: evaluates one element per clock, merges the
// results into the old destination mask under vm/v0 and vl, and pulses done.
// Assumes: vs2_i and vs1_i stay stable while busy_o is high; the other inputs
// are sampled at the accepted start.
module fp_cmp_mask_unit
    import fpcmp_pkg::*;
#(
    parameter int NUM_ELEM = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [5:0]                 funct6_i,
    input  logic                       vm_i,
    input  logic [2:0]                 form_i,
    input  logic [1:0]                 sew_i,
    input  logic [$clog2(NUM_ELEM+1)-1:0] vl_i,
    input  logic [2:0]                 frm_i,
    input  logic [LANE_W*NUM_ELEM-1:0] vs2_i,
    input  logic [LANE_W*NUM_ELEM-1:0] vs1_i,
    input  logic [LANE_W-1:0]          scal_i,
    input  logic [NUM_ELEM-1:0]        v0_i,
    input  logic [NUM_ELEM-1:0]        old_mask_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [NUM_ELEM-1:0]        mask_o,
    output logic                       flag_nv_o,
    output logic                       illegal_o
);
    localparam int CNT_W = $clog2(NUM_ELEM + 1);
    localparam int IDX_W = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1;
    localparam logic [CNT_W-1:0] MAX_VL = CNT_W'(NUM_ELEM);

    logic                busy_q, done_q, ill_q, nv_q, vm_q, scalar_q;
    logic [NUM_ELEM-1:0] mask_q, v0_q;
    logic [IDX_W-1:0]    idx_q, last_q;
    cmp_op_e             op_q;
    sew_e                sew_q;
    logic [LANE_W-1:0]   scal_q;

    logic                dec_ill, dec_scalar;
    logic [CNT_W-1:0]    vl_cl;
    logic [LANE_W-1:0]   lane_a [NUM_ELEM];
    logic [LANE_W-1:0]   lane_b [NUM_ELEM];
    logic [LANE_W-1:0]   a_raw, b_raw;
    fp_class_t           a_cls, b_cls;
    logic                elem_res, elem_nv, elem_active;

    fpcmp_decode u_decode (
        .funct6_i  (funct6_i),
        .form_i    (form_i),
        .sew_i     (sew_i),
        .frm_i     (frm_i),
        .illegal_o (dec_ill),
        .scalar_o  (dec_scalar)
    );

    // Split the operand buses into one lane per element.
    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_lane
        assign lane_a[g] = vs2_i[g*LANE_W +: LANE_W];
        assign lane_b[g] = vs1_i[g*LANE_W +: LANE_W];
    end

    // Clamp the count and choose the second operand for the current element.
    always_comb begin
        vl_cl       = (vl_i > MAX_VL) ? MAX_VL : vl_i;
        a_raw       = lane_a[idx_q];
        b_raw       = scalar_q ? scal_q : lane_b[idx_q];
        elem_active = vm_q || v0_q[idx_q];
    end

    fpcmp_classify u_cls_a (
        .raw_i    (a_raw),
        .sew_i    (sew_q),
        .box_en_i (1'b0),
        .cls_o    (a_cls)
    );

    fpcmp_classify u_cls_b (
        .raw_i    (b_raw),
        .sew_i    (sew_q),
        .box_en_i (scalar_q),
        .cls_o    (b_cls)
    );

    fpcmp_elem u_elem (
        .a_i   (a_cls),
        .b_i   (b_cls),
        .op_i  (op_q),
        .res_o (elem_res),
        .nv_o  (elem_nv)
    );

    // Accept a start, step through the elements and raise the completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            ill_q    <= 1'b0;
            nv_q     <= 1'b0;
            vm_q     <= 1'b0;
            scalar_q <= 1'b0;
            mask_q   <= '0;
            v0_q     <= '0;
            idx_q    <= '0;
            last_q   <= '0;
            op_q     <= CMP_EQ;
            sew_q    <= SEW_64;
            scal_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q && start_i) begin
                op_q     <= cmp_op_e'(funct6_i);
                sew_q    <= sew_e'(sew_i);
                scalar_q <= dec_scalar;
                vm_q     <= vm_i;
                v0_q     <= v0_i;
                scal_q   <= scal_i;
                mask_q   <= old_mask_i;
                nv_q     <= 1'b0;
                ill_q    <= dec_ill;
                idx_q    <= '0;
                last_q   <= IDX_W'(vl_cl - 1'b1);
                if (dec_ill || vl_cl == '0) done_q <= 1'b1;
                else                        busy_q <= 1'b1;
            end else if (busy_q) begin
                if (elem_active) begin
                    mask_q[idx_q] <= elem_res;
                    if (elem_nv) nv_q <= 1'b1;
                end
                if (idx_q == last_q) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign busy_o    = busy_q;
    assign done_o    = done_q;
    assign mask_o    = mask_q;
    assign flag_nv_o = nv_q;
    assign illegal_o = ill_q;

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !done_o); // R10
    AST_IDLE_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(mask_o)); // R10
    AST_SEW8_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && sew_i == 2'd0) |=> (done_o && illegal_o)); // R2
    AST_ILLEGAL_KEEPS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && illegal_o) |-> (mask_o == $past(old_mask_i) && !flag_nv_o)); // R2
    AST_NV_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> !flag_nv_o); // R6
endmodule

// File: tb/test_fp_cmp_mask_unit.sv
`timescale 1ns/1ps
module test_fp_cmp_mask_unit;
    localparam int N  = 8;
    localparam int CW = $clog2(N + 1);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [5:0]     funct6_i = '0;
    logic           vm_i = 1'b1;
    logic [2:0]     form_i = 3'b001;
    logic [1:0]     sew_i = 2'd2;
    logic [CW-1:0]  vl_i = '0;
    logic [2:0]     frm_i = '0;
    logic [64*N-1:0] vs2_i = '0;
    logic [64*N-1:0] vs1_i = '0;
    logic [63:0]    scal_i = '0;
    logic [N-1:0]   v0_i = '0;
    logic [N-1:0]   old_mask_i = '0;
    logic           busy_o, done_o, flag_nv_o, illegal_o;
    logic [N-1:0]   mask_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [63:0] ea [N];
    logic [63:0] eb [N];

    logic [N-1:0] q_mask [$];
    logic         q_nv   [$];
    logic         q_ill  [$];
    string        q_tag  [$];

    always #2.5 clk = ~clk;

    fp_cmp_mask_unit #(.NUM_ELEM(N)) i_fp_cmp_mask_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .funct6_i(funct6_i),
        .vm_i(vm_i), .form_i(form_i), .sew_i(sew_i), .vl_i(vl_i), .frm_i(frm_i),
        .vs2_i(vs2_i), .vs1_i(vs1_i), .scal_i(scal_i), .v0_i(v0_i),
        .old_mask_i(old_mask_i), .busy_o(busy_o), .done_o(done_o),
        .mask_o(mask_o), .flag_nv_o(flag_nv_o), .illegal_o(illegal_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Reference compare built on an ordered integer key per value.
    function automatic void model_cmp(input logic [5:0] op, input logic [63:0] a_in,
                                      input logic [63:0] b_in, input int w,
                                      output logic r, output logic nv);
        int ew, mw;
        longint unsigned msk, half, am, bm, ka, kb, a, b;
        logic na, nb, sa, sb, za, zb, eqv, ltv, gtv, ord;
        ew   = (w == 16) ? 5 : (w == 32) ? 8 : 11;
        mw   = w - 1 - ew;
        msk  = (w == 64) ? ~64'd0 : ((64'd1 << w) - 1);
        a    = a_in & msk;
        b    = b_in & msk;
        half = 64'd1 << (w - 1);
        am   = a & (half - 1);
        bm   = b & (half - 1);
        na = ((am >> mw) == ((64'd1 << ew) - 1)) && ((am & ((64'd1 << mw) - 1)) != 0);
        nb = ((bm >> mw) == ((64'd1 << ew) - 1)) && ((bm & ((64'd1 << mw) - 1)) != 0);
        sa = na && !a[mw-1];
        sb = nb && !b[mw-1];
        za = (am == 0);
        zb = (bm == 0);
        ka = a[w-1] ? (half - 1 - am) : (half + am);
        kb = b[w-1] ? (half - 1 - bm) : (half + bm);
        eqv = !(na || nb) && ((ka == kb) || (za && zb));
        ltv = !(na || nb) && !(za && zb) && (ka < kb);
        gtv = !(na || nb) && !(za && zb) && (ka > kb);
        case (op)
            6'h18:   r = eqv;
            6'h19:   r = ltv | eqv;
            6'h1B:   r = ltv;
            6'h1C:   r = !eqv;
            6'h1D:   r = gtv;
            default: r = gtv | eqv;
        endcase
        ord = !(op == 6'h18 || op == 6'h1C);
        nv  = ord ? (na || nb) : (sa || sb);
    endfunction

    // Driver: predict, push to the scoreboard, start, and check completion timing.
    task automatic run_op(input logic [5:0] op, input logic [2:0] form, input logic [1:0] sew,
                          input logic [2:0] frm, input logic vm, input int vl,
                          input logic [N-1:0] v0, input logic [N-1:0] old,
                          input logic [63:0] scal, input string tag, input bit kick);
        logic [N-1:0] em;
        logic env, legal, r, nv;
        logic [63:0] b;
        int w, lat, n_eff, exp_lat;
        w = (sew == 2'd1) ? 16 : (sew == 2'd2) ? 32 : 64;
        legal = (sew != 2'd0) && (frm <= 3'd4) &&
                ((form == 3'b001 && (op == 6'h18 || op == 6'h19 || op == 6'h1B || op == 6'h1C)) ||
                 (form == 3'b101 && (op == 6'h18 || op == 6'h19 || op == 6'h1B || op == 6'h1C ||
                                     op == 6'h1D || op == 6'h1F)));
        n_eff = (vl > N) ? N : vl;
        em = old;
        env = 1'b0;
        if (legal) begin
            for (int i = 0; i < n_eff; i++) begin
                if (vm || v0[i]) begin
                    b = (form == 3'b101) ? scal : eb[i];
                    if (form == 3'b101 && w < 64 && (scal >> w) != (~64'd0 >> w))
                        b = (w == 16) ? 64'h7E00 : 64'h7FC0_0000;
                    model_cmp(op, ea[i], b, w, r, nv);
                    em[i] = r;
                    env = env | nv;
                end
            end
        end
        q_mask.push_back(em);
        q_nv.push_back(env);
        q_ill.push_back(!legal);
        q_tag.push_back(tag);
        exp_lat = (!legal || n_eff == 0) ? 1 : n_eff + 1;

        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            vs2_i[i*64 +: 64] = ea[i];
            vs1_i[i*64 +: 64] = eb[i];
        end
        funct6_i = op; form_i = form; sew_i = sew; frm_i = frm; vm_i = vm;
        vl_i = CW'(vl); v0_i = v0; old_mask_i = old; scal_i = scal;
        start_i = 1'b1;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            start_i = 1'b0;
            if (kick && lat == 2) begin
                start_i = 1'b1;
                funct6_i = 6'h1C;
                old_mask_i = ~old;
            end
        end while (!done_o && lat < 100);
        start_i = 1'b0;
        chk(lat == exp_lat, kick ? "R11" : "R10", {tag, " latency"}, lat, exp_lat);
    endtask

    // Monitor: pop and compare each result on the completion pulse.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (q_mask.size() == 0) begin
                chk(1'b0, "R10", "unexpected done", 1, 0);
            end else begin
                string t;
                logic [N-1:0] m;
                logic nvv, il;
                m = q_mask.pop_front(); nvv = q_nv.pop_front();
                il = q_ill.pop_front(); t = q_tag.pop_front();
                chk(mask_o == m, t, "mask", mask_o, m);
                chk(flag_nv_o == nvv, t, "invalid flag R6", flag_nv_o, nvv);
                chk(illegal_o == il, t, "illegal R1", illegal_o, il);
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        chk(!busy_o && !done_o && !illegal_o && !flag_nv_o && mask_o == '0, "R12",
            "reset outputs", {busy_o, done_o, illegal_o, flag_nv_o, mask_o}, 0);

        // 32-bit lanes with junk in the upper half (R9), zeros (R4), NaNs (R3)
        ea[0] = 64'hDEAD_BEEF_3F80_0000; eb[0] = 64'h1234_5678_3F80_0000;
        ea[1] = 64'hDEAD_BEEF_0000_0000; eb[1] = 64'h0000_0000_8000_0000;
        ea[2] = 64'h0000_0000_3F80_0000; eb[2] = 64'hFFFF_FFFF_4000_0000;
        ea[3] = 64'h0000_0000_7FC0_0000; eb[3] = 64'h0000_0000_7FC0_0000;
        ea[4] = 64'h0000_0000_C000_0000; eb[4] = 64'h0000_0000_C000_0000;
        ea[5] = 64'h0000_0000_7F80_0001; eb[5] = 64'h0000_0000_3F80_0000;
        ea[6] = 64'h0000_0000_7F80_0000; eb[6] = 64'h0000_0000_7F80_0000;
        ea[7] = 64'h0000_0000_BF80_0000; eb[7] = 64'h0000_0000_3F80_0000;
        run_op(6'h18, 3'b001, 2'd2, 3'd0, 1'b1, 8, '0, 8'h00, '0, "R3/R4/R9 eq32", 0);
        run_op(6'h1B, 3'b001, 2'd2, 3'd1, 1'b1, 8, '0, 8'hFF, '0, "R3/R6 lt32", 0);
        run_op(6'h19, 3'b001, 2'd2, 3'd4, 1'b1, 8, '0, 8'h00, '0, "R4/R5 le32", 0);
        run_op(6'h1C, 3'b001, 2'd2, 3'd0, 1'b1, 8, '0, 8'h00, '0, "R3/R6 ne32", 0);

        // 64-bit ordering with negatives and infinities (R5)
        ea[0] = 64'hBFF0_0000_0000_0000; eb[0] = 64'hC000_0000_0000_0000;
        ea[1] = 64'hC000_0000_0000_0000; eb[1] = 64'hBFF0_0000_0000_0000;
        ea[2] = 64'h8000_0000_0000_0000; eb[2] = 64'h0000_0000_0000_0000;
        ea[3] = 64'h3FF0_0000_0000_0000; eb[3] = 64'h4000_0000_0000_0000;
        ea[4] = 64'hBFF0_0000_0000_0000; eb[4] = 64'h3FF0_0000_0000_0000;
        ea[5] = 64'h4000_0000_0000_0000; eb[5] = 64'hFFF0_0000_0000_0000;
        ea[6] = 64'h0000_0000_0000_0001; eb[6] = 64'h0000_0000_0000_0000;
        ea[7] = 64'h4000_0000_0000_0000; eb[7] = 64'h4000_0000_0000_0000;
        run_op(6'h1B, 3'b001, 2'd3, 3'd0, 1'b1, 8, '0, 8'h00, '0, "R5 lt64", 0);
        run_op(6'h19, 3'b001, 2'd3, 3'd0, 1'b1, 8, '0, 8'h00, '0, "R5 le64", 0);

        // 16-bit lanes
        ea[0] = 64'h3C00; eb[0] = 64'h4000;
        ea[1] = 64'hBC00; eb[1] = 64'hC000;
        ea[2] = 64'h7E00; eb[2] = 64'h3C00;
        ea[3] = 64'h7C01; eb[3] = 64'h7C01;
        ea[4] = 64'h8000; eb[4] = 64'h0000;
        ea[5] = 64'h7C00; eb[5] = 64'h4000;
        ea[6] = 64'hC000; eb[6] = 64'hBC00;
        ea[7] = 64'h4000; eb[7] = 64'h3C00;
        run_op(6'h19, 3'b001, 2'd1, 3'd0, 1'b1, 8, '0, 8'h00, '0, "R5/R6 le16", 0);
        run_op(6'h18, 3'b001, 2'd1, 3'd0, 1'b1, 8, '0, 8'hFF, '0, "R6 eq16 snan", 0);

        // Scalar forms, properly boxed (R1, R8)
        ea[0] = 64'h3F80_0000; ea[1] = 64'h4000_0000; ea[2] = 64'hBF80_0000;
        ea[3] = 64'h7FC0_0000; ea[4] = 64'h0000_0000; ea[5] = 64'h7F80_0000;
        ea[6] = 64'h3F7F_FFFF; ea[7] = 64'h3F80_0001;
        run_op(6'h1D, 3'b101, 2'd2, 3'd0, 1'b1, 8, '0, 8'h00, 64'hFFFF_FFFF_3F80_0000, "R1 gt32 scalar", 0);
        run_op(6'h1F, 3'b101, 2'd2, 3'd0, 1'b1, 8, '0, 8'h00, 64'hFFFF_FFFF_3F80_0000, "R1 ge32 scalar", 0);
        run_op(6'h1C, 3'b101, 2'd2, 3'd0, 1'b1, 8, '0, 8'h00, 64'hFFFF_FFFF_3F80_0000, "R1 ne32 scalar", 0);
        // Badly boxed scalar acts as quiet NaN (R8)
        run_op(6'h18, 3'b101, 2'd2, 3'd0, 1'b1, 8, '0, 8'hFF, 64'h0000_FFFF_3F80_0000, "R8 eq unboxed", 0);
        run_op(6'h1B, 3'b101, 2'd2, 3'd0, 1'b1, 8, '0, 8'hFF, 64'h0000_FFFF_3F80_0000, "R8 lt unboxed", 0);

        // Masking and tail (R7)
        for (int i = 0; i < N; i++) eb[i] = ea[i];
        run_op(6'h18, 3'b001, 2'd2, 3'd0, 1'b0, 5, 8'b0110_1001, 8'hA5, '0, "R7 masked tail", 0);
        run_op(6'h1C, 3'b001, 2'd2, 3'd0, 1'b0, 8, 8'b1000_0010, 8'h7D, '0, "R7 masked ne", 0);

        // Illegal requests (R1, R2)
        run_op(6'h1D, 3'b001, 2'd2, 3'd0, 1'b1, 8, '0, 8'h3C, '0, "R1 gt in vv form", 0);
        run_op(6'h1A, 3'b101, 2'd2, 3'd0, 1'b1, 8, '0, 8'h5A, '0, "R1 bad opcode", 0);
        run_op(6'h18, 3'b000, 2'd2, 3'd0, 1'b1, 8, '0, 8'h11, '0, "R1 bad form", 0);
        run_op(6'h18, 3'b001, 2'd0, 3'd0, 1'b1, 8, '0, 8'h96, '0, "R2 sew8", 0);
        run_op(6'h18, 3'b001, 2'd2, 3'd5, 1'b1, 8, '0, 8'hC3, '0, "R2 frm5", 0);
        run_op(6'h18, 3'b001, 2'd2, 3'd7, 1'b1, 8, '0, 8'h0F, '0, "R2 frm7", 0);

        // Zero count and start while busy (R10, R11)
        run_op(6'h18, 3'b001, 2'd2, 3'd0, 1'b1, 0, '0, 8'hE7, '0, "R10 zero count", 0);
        run_op(6'h18, 3'b001, 2'd2, 3'd0, 1'b1, 1, '0, 8'h00, '0, "R10 single", 0);
        ea[3] = 64'h7F80_0001;
        run_op(6'h18, 3'b001, 2'd2, 3'd0, 1'b1, 8, '0, 8'h00, '0, "R11 busy start", 1);

        // Result held while idle (R10)
        begin
            logic [N-1:0] held;
            held = mask_o;
            repeat (4) @(negedge clk);
            chk(mask_o == held && !done_o, "R10", "mask held idle", mask_o, held);
        end
        chk(q_mask.size() == 0, "R10", "scoreboard drained", q_mask.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule